// File: doc/BRIEF.md
# Modem-Line Status and Interrupt Latch

This block is the external/status part of one serial channel. It watches two asynchronous, active-low modem lines, clear-to-send and carrier-detect, and passes each through a synchroniser. A status read register shows the lines as they are. When either line changes and that source is enabled, the block raises an interrupt and freezes the status register, so software reads the line state that caused the event.

The same line activity can also switch the channel on without software. With auto-enable mode selected, clear-to-send going active turns on the transmitter, and carrier-detect going active turns on the receiver. Software clears the interrupt and the freeze with a command write to register 0. From then on the status register again follows the lines.

Access is through a plain write port with a combinational read port. The port is addressed by register number.

Top module: `modem_status_latch`

## Requirements
- R1: After reset, register 0 reads 0x00, register 15 reads 0x00, and `ext_irq`, `tx_en` and `rx_en` are low. Both lines are sampled as inactive (high).
- R2: While no interrupt is pending, register 0 follows the lines within three clock edges. Bit 5 is 1 while `cts_n` is low, bit 3 is 1 while `dcd_n` is low, and all other bits are 0.
- R3: When `cts_n` goes low and register 3 bit 5 (auto-enable) is set, hardware sets register 5 bit 3 (transmit enable, driven on `tx_en`). A rising `cts_n`, or a falling `cts_n` with auto-enable clear, leaves that bit unchanged.
- R4: When `dcd_n` goes low and register 3 bit 5 is set, hardware sets register 3 bit 0 (receive enable, driven on `rx_en`).
- R5: A change of either level on a line raises `ext_irq` only if register 1 bit 0 is set and the matching enable bit in register 15 is set. The clear-to-send enable is bit 5 and the carrier-detect enable is bit 3.
- R6: Raising the interrupt freezes register 0 at the line state of that moment. Later line changes do not alter register 0 while the interrupt is pending.
- R7: Register 15 reads back the last value written to it ANDed with 0xFA.
- R8: A write to register 0 whose bits 5:3 equal 3'b010 (for example 0x10) clears `ext_irq` and the freeze, after which register 0 tracks the lines again. A write to register 0 with any other code has no effect.
- R9: Once raised, `ext_irq` stays high until the reset command of R8 is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cts_n | input | 1 | Clear-to-send line, active low, asynchronous |
| dcd_n | input | 1 | Carrier-detect line, active low, asynchronous |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register number for read and write |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| ext_irq | output | 1 | External/status interrupt request, held until cleared |
| tx_en | output | 1 | Transmit enable (register 5 bit 3) |
| rx_en | output | 1 | Receive enable (register 3 bit 0) |

## Verification
Each line is driven alone and then together with the other. This shows whether each status bit follows its own line in the correct polarity. Edges are applied in both directions, with auto-enable set and clear, to separate the active edge that may switch a channel on from an edge that must not. Interrupt tests pair every line with each enable setting: global enable off, only the other source enabled, and the matching source enabled. Line changes made while frozen, followed by a non-reset and then a reset command, separate a frozen register from one that is still following the lines.

// File: rtl/modem_status_latch.sv
module modem_status_latch #(
  parameter int AW          = 4,
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2,
  parameter int CTS_BIT     = 5,
  parameter int DCD_BIT     = 3,
  parameter int AUTO_BIT    = 5,
  parameter int RXEN_BIT    = 0,
  parameter int TXEN_BIT    = 3,
  parameter int IE_BIT      = 0,
  parameter logic [DW-1:0] SRC_MASK = 8'hFA,
  parameter logic [2:0]    RST_CMD  = 3'd2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cts_n,
  input  logic          dcd_n,
  input  logic          reg_we,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          ext_irq,
  output logic          tx_en,
  output logic          rx_en
);
  localparam logic [AW-1:0] A_CMD  = AW'(0);
  localparam logic [AW-1:0] A_IE   = AW'(1);
  localparam logic [AW-1:0] A_RXC  = AW'(3);
  localparam logic [AW-1:0] A_TXC  = AW'(5);
  localparam logic [AW-1:0] A_SRC  = AW'(15);
  localparam int            TOP    = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] cts_sync, dcd_sync;
  logic cts_prev, dcd_prev;
  logic sts_cts, sts_dcd, frozen, ext_ie;
  logic [DW-1:0] rxc, txc, src_en;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cts_sync <= '1;
      dcd_sync <= '1;
      cts_prev <= 1'b1;
      dcd_prev <= 1'b1;
    end else begin
      cts_sync <= {cts_sync[TOP-1:0], cts_n};
      dcd_sync <= {dcd_sync[TOP-1:0], dcd_n};
      cts_prev <= cts_sync[TOP];
      dcd_prev <= dcd_sync[TOP];
    end

  wire cts_now  = cts_sync[TOP];
  wire dcd_now  = dcd_sync[TOP];
  wire cts_chg  = cts_now ^ cts_prev;
  wire dcd_chg  = dcd_now ^ dcd_prev;
  wire cts_fall = cts_chg & ~cts_now;
  wire dcd_fall = dcd_chg & ~dcd_now;
  wire auto_en  = rxc[AUTO_BIT];
  wire raise    = ext_ie & ((cts_chg & src_en[CTS_BIT]) | (dcd_chg & src_en[DCD_BIT]));
  wire rst_cmd  = reg_we && reg_addr == A_CMD && reg_wdata[5:3] == RST_CMD;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      frozen  <= 1'b0;
      sts_cts <= 1'b0;
      sts_dcd <= 1'b0;
    end else begin
      if (!frozen) begin
        sts_cts <= ~cts_now;
        sts_dcd <= ~dcd_now;
      end
      if (raise)        frozen <= 1'b1;
      else if (rst_cmd) frozen <= 1'b0;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ext_ie <= 1'b0;
      rxc    <= '0;
      txc    <= '0;
      src_en <= '0;
    end else begin
      if (reg_we && reg_addr == A_IE)  ext_ie <= reg_wdata[IE_BIT];
      if (reg_we && reg_addr == A_SRC) src_en <= reg_wdata;
      if (reg_we && reg_addr == A_RXC) rxc    <= reg_wdata;
      if (reg_we && reg_addr == A_TXC) txc    <= reg_wdata;
      if (dcd_fall && auto_en) rxc[RXEN_BIT] <= 1'b1;
      if (cts_fall && auto_en) txc[TXEN_BIT] <= 1'b1;
    end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CMD: begin
        reg_rdata[CTS_BIT] = sts_cts;
        reg_rdata[DCD_BIT] = sts_dcd;
      end
      A_IE:  reg_rdata[IE_BIT] = ext_ie;
      A_RXC: reg_rdata = rxc;
      A_TXC: reg_rdata = txc;
      A_SRC: reg_rdata = src_en & SRC_MASK;
      default: reg_rdata = '0;
    endcase
  end

  assign ext_irq = frozen;
  assign tx_en   = txc[TXEN_BIT];
  assign rx_en   = rxc[RXEN_BIT];
endmodule

module modem_status_latch_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_we,
  input logic [3:0] reg_addr,
  input logic [7:0] reg_wdata,
  input logic [7:0] reg_rdata,
  input logic       ext_irq,
  input logic       tx_en,
  input logic       rx_en,
  input logic       cts_fall,
  input logic       dcd_fall,
  input logic       auto_en,
  input logic       ext_ie,
  input logic       sts_cts,
  input logic       sts_dcd
);
  wire clr_cmd = reg_we && reg_addr == 4'd0 && reg_wdata[5:3] == 3'b010;

  AST_FROZEN_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_irq && $past(ext_irq)) |-> ($stable(sts_cts) && $stable(sts_dcd))); // R6
  AST_IRQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_irq && !clr_cmd) |=> ext_irq); // R9
  AST_TX_AUTO: assert property (@(posedge clk) disable iff (!rst_n)
    (cts_fall && auto_en) |=> tx_en); // R3
  AST_RX_AUTO: assert property (@(posedge clk) disable iff (!rst_n)
    (dcd_fall && auto_en) |=> rx_en); // R4
  AST_NO_IRQ_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_irq && !ext_ie) |=> !ext_irq); // R5
  AST_SRC_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 4'd15) |-> (reg_rdata[0] == 1'b0 && reg_rdata[2] == 1'b0)); // R7
endmodule

bind modem_status_latch modem_status_latch_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ext_irq(ext_irq),
  .tx_en(tx_en), .rx_en(rx_en), .cts_fall(cts_fall), .dcd_fall(dcd_fall),
  .auto_en(auto_en), .ext_ie(ext_ie), .sts_cts(sts_cts), .sts_dcd(sts_dcd)
);

// File: tb/modem_status_latch_tb.sv
module modem_status_latch_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 6;
  localparam logic [7:0] WV [NV] = '{8'hFF, 8'h05, 8'h08, 8'h20, 8'hA7, 8'h5A};
  localparam logic [7:0] EV [NV] = '{8'hFA, 8'h00, 8'h08, 8'h20, 8'hA2, 8'h5A};

  logic clk = 0, rst_n = 0, cts_n = 1, dcd_n = 1, reg_we = 0;
  logic [3:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic ext_irq, tx_en, rx_en;
  int checks = 0, fails = 0;

  modem_status_latch u_dut (
    .clk(clk), .rst_n(rst_n), .cts_n(cts_n), .dcd_n(dcd_n),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .ext_irq(ext_irq), .tx_en(tx_en), .rx_en(rx_en));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd(logic [3:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++; checks++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    rd(0, v); chk("R1 status", v, 8'h00);
    rd(15, v); chk("R1 srcen", v, 8'h00);
    chk("R1 irq/tx/rx", {5'b0, ext_irq, tx_en, rx_en}, 8'h00);

    for (int i = 0; i < NV; i++) begin
      wr(15, WV[i]); rd(15, v); chk("R7 mask", v, EV[i]);
    end
    wr(15, 8'h00);

    cts_n = 0; settle(); rd(0, v); chk("R2 cts only", v, 8'h20);
    dcd_n = 0; settle(); rd(0, v); chk("R2 both", v, 8'h28);
    cts_n = 1; settle(); rd(0, v); chk("R2 dcd only", v, 8'h08);
    dcd_n = 1; settle(); rd(0, v); chk("R2 none", v, 8'h00);
    chk("R3 no auto tx", {7'b0, tx_en}, 8'h00);
    chk("R5 disabled irq", {7'b0, ext_irq}, 8'h00);

    wr(3, 8'h20);
    cts_n = 0; settle(); chk("R3 auto tx", {7'b0, tx_en}, 8'h01);
    rd(5, v); chk("R3 reg5", v, 8'h08);
    wr(5, 8'h00);
    cts_n = 1; settle(); chk("R3 rising no tx", {7'b0, tx_en}, 8'h00);
    dcd_n = 0; settle(); chk("R4 auto rx", {7'b0, rx_en}, 8'h01);
    rd(3, v); chk("R4 reg3", v, 8'h21);
    dcd_n = 1; wr(3, 8'h00); settle();

    wr(1, 8'h01); wr(15, 8'h08);
    cts_n = 0; settle(); chk("R5 other src", {7'b0, ext_irq}, 8'h00);
    cts_n = 1; settle();
    dcd_n = 0; settle(); chk("R5 dcd irq", {7'b0, ext_irq}, 8'h01);
    rd(0, v); chk("R6 captured", v, 8'h08);
    dcd_n = 1; cts_n = 0; settle();
    rd(0, v); chk("R6 frozen", v, 8'h08);
    chk("R9 held", {7'b0, ext_irq}, 8'h01);
    wr(0, 8'h08); chk("R8 other cmd", {7'b0, ext_irq}, 8'h01);
    rd(0, v); chk("R8 still frozen", v, 8'h08);
    wr(0, 8'h10); chk("R8 cleared", {7'b0, ext_irq}, 8'h00);
    settle(); rd(0, v); chk("R8 tracking", v, 8'h20);

    wr(15, 8'h20);
    cts_n = 1; settle(); chk("R5 cts rise irq", {7'b0, ext_irq}, 8'h01);
    rd(0, v); chk("R6 cts capture", v, 8'h00);
    wr(0, 8'h10);
    wr(1, 8'h00); wr(15, 8'h28);
    dcd_n = 0; settle(); chk("R5 global off", {7'b0, ext_irq}, 8'h00);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule